// File: doc/BRIEF.md
# Single-Cycle Reduced RISC-V Core

This block is a small 32-bit processor for a reduced RISC-V integer subset. Each instruction is fetched from instruction memory, decoded, given its operands from the register file, executed in the ALU or data memory, and written back, all within one clock. The program counter and the register file change on that same rising edge. The architectural register file has eight entries, and register 0 is hard-wired to zero.

The instruction memory is filled through a word-wide load port, which the surrounding environment (or a testbench) drives while the core is held in reset. Both memories are word-addressed, read combinationally and written on the clock edge. One architectural register, chosen by a parameter, is brought out on a debug port so that the result of a program can be observed. The next PC is PC+4 unless a taken branch or a jump redirects it. There is no prediction.

Top module: `rvl_core`

## Requirements
- R1: The core retires one instruction per clock. After reset the PC is 0. On each rising edge it advances by 4 unless a taken branch or a jump redirects it.
- R2: Opcode 0110011 performs register-register operations on rs1 and rs2. With funct7=0000000: funct3 000 ADD, 010 SLT (signed less-than gives 1, else 0), 110 OR and 111 AND. With funct7=0100000 and funct3 000: SUB.
- R3: Opcode 0010011 with funct3 000 (ADDI) writes rs1 plus the sign-extended 12-bit immediate from bits [31:20] into rd.
- R4: Register fields index the file with their low 3 bits only. Register 0 reads as zero, and writes to it are discarded.
- R5: LW (opcode 0000011, funct3 010) and SW (opcode 0100011, funct3 010) use the word addressed by rs1 plus the immediate. Address bits [1:0] are ignored. A store takes effect at the clock edge, and a load returns the stored word in the same cycle it executes.
- R6: BEQ (opcode 1100011, funct3 000) and BNE (funct3 001) compare rs1 with rs2. When the condition holds, the next PC is the PC plus the sign-extended B-format immediate. Otherwise it is PC+4.
- R7: JAL (opcode 1101111) writes PC+4 into rd and moves the PC by the sign-extended J-format immediate.
- R8: JALR (opcode 1100111, funct3 000) writes PC+4 into rd and jumps to (rs1 + I-immediate) with bit 0 cleared.
- R9: Any opcode or function combination outside the supported set executes as a no-op. It writes no register and no memory, and only advances the PC by 4.
- R10: While rst_n is low the PC is held at 0 and every register reads zero, including the debug port.
- R11: A loop that adds 1 through 10 into a register leaves 55 there and then rests on a self-jump.
- R12: A store never writes the register file, even when its immediate bits occupy the rd field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_we | input | 1 | Write strobe for the instruction-memory load port |
| load_addr | input | IMEM_AW | Word index written by the load port |
| load_data | input | 32 | Instruction word written by the load port |
| pc_o | output | 32 | Current program counter |
| dbg_o | output | 32 | Contents of the register selected by DBG_IDX |

## Verification
The bench targets the places where a single-cycle datapath tends to go wrong. It checks sign extension with negative operands and the largest positive immediate; a wrong extension gives a large positive sum. It checks register fields above 7, which a design without the low-3-bit fold would send to the wrong entry. It sends a store whose immediate bits occupy the rd field; a decoder that leaks the register write enable would corrupt that register. It also runs a JALR to an odd target, a BEQ that is taken, a BNE that is not taken, and a backward branch in the sum loop. A core that forgets to clear bit 0, inverts the branch sense or mis-assembles the scattered B- or J-immediate bits lands on the wrong PC, and the bench observes that PC directly.

// File: rtl/rvl_pkg.sv
// Package: shared opcodes, control encodings and the decoded control bundle
// for the single-cycle reduced core. Assumes RV32 base encodings.
package rvl_pkg;

    localparam logic [6:0] OPC_REG  = 7'b0110011;
    localparam logic [6:0] OPC_IMM  = 7'b0010011;
    localparam logic [6:0] OPC_LOAD = 7'b0000011;
    localparam logic [6:0] OPC_STOR = 7'b0100011;
    localparam logic [6:0] OPC_BRCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL  = 7'b1101111;
    localparam logic [6:0] OPC_JALR = 7'b1100111;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    // writeback source: 0 ALU, 1 memory, 2 link address
    typedef enum logic [1:0] {
        WB_ALU = 2'd0,
        WB_MEM = 2'd1,
        WB_PC4 = 2'd2
    } wb_sel_e;

    typedef enum logic [1:0] {
        IMM_I = 2'd0,
        IMM_S = 2'd1,
        IMM_B = 2'd2,
        IMM_J = 2'd3
    } imm_kind_e;

    typedef struct packed {
        logic      reg_we;
        logic      mem_we;
        alu_op_e   alu_op;
        logic      b_is_imm;
        logic      branch;
        logic      br_ne;
        logic      jump;
        logic      jalr;
        wb_sel_e   wb_sel;
        imm_kind_e imm_kind;
    } ctrl_t;

endpackage

// File: rtl/rvl_decoder.sv
// Control decoder: turns opcode/funct fields into the control bundle.
// Assumes: anything not in the supported set decodes to a pure no-op
// (no register write, no memory write, no redirect).
module rvl_decoder
    import rvl_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output ctrl_t      ctrl
);

    // Combinational decode of one instruction word
    always_comb begin
        ctrl          = '0;
        ctrl.alu_op   = ALU_ADD;
        ctrl.wb_sel   = WB_ALU;
        ctrl.imm_kind = IMM_I;
        unique case (opcode)
            OPC_REG: begin
                if (funct7 == 7'b0000000) begin
                    unique case (funct3)
                        3'b000:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
                        3'b010:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
                        3'b110:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_OR;  end
                        3'b111:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
                        default: ;
                    endcase
                end else if (funct7 == 7'b0100000 && funct3 == 3'b000) begin
                    ctrl.reg_we = 1'b1;
                    ctrl.alu_op = ALU_SUB;
                end
            end
            OPC_IMM: begin
                if (funct3 == 3'b000) begin
                    ctrl.reg_we   = 1'b1;
                    ctrl.b_is_imm = 1'b1;
                end
            end
            OPC_LOAD: begin
                if (funct3 == 3'b010) begin
                    ctrl.reg_we   = 1'b1;
                    ctrl.b_is_imm = 1'b1;
                    ctrl.wb_sel   = WB_MEM;
                end
            end
            OPC_STOR: begin
                if (funct3 == 3'b010) begin
                    ctrl.mem_we   = 1'b1;
                    ctrl.b_is_imm = 1'b1;
                    ctrl.imm_kind = IMM_S;
                end
            end
            OPC_BRCH: begin
                if (funct3 == 3'b000 || funct3 == 3'b001) begin
                    ctrl.branch   = 1'b1;
                    ctrl.br_ne    = funct3[0];
                    ctrl.alu_op   = ALU_SUB;
                    ctrl.imm_kind = IMM_B;
                end
            end
            OPC_JAL: begin
                ctrl.reg_we   = 1'b1;
                ctrl.jump     = 1'b1;
                ctrl.wb_sel   = WB_PC4;
                ctrl.imm_kind = IMM_J;
            end
            OPC_JALR: begin
                if (funct3 == 3'b000) begin
                    ctrl.reg_we   = 1'b1;
                    ctrl.jump     = 1'b1;
                    ctrl.jalr     = 1'b1;
                    ctrl.b_is_imm = 1'b1;
                    ctrl.wb_sel   = WB_PC4;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rvl_immgen.sv
// Immediate generator: rebuilds and sign-extends the I, S, B or J immediate.
// Assumes the caller passes instruction bits [31:7]; B and J results have
// bit 0 forced to zero by the format.
module rvl_immgen
    import rvl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:7]     ib,
    input  imm_kind_e       kind,
    output logic [XLEN-1:0] imm
);

    // Select the immediate layout for the current format
    always_comb begin
        unique case (kind)
            IMM_I: imm = {{(XLEN-12){ib[31]}}, ib[31:20]};
            IMM_S: imm = {{(XLEN-12){ib[31]}}, ib[31:25], ib[11:7]};
            IMM_B: imm = {{(XLEN-13){ib[31]}}, ib[31], ib[7], ib[30:25], ib[11:8], 1'b0};
            default: imm = {{(XLEN-21){ib[31]}}, ib[31], ib[19:12], ib[20], ib[30:21], 1'b0};
        endcase
    end

endmodule

// File: rtl/rvl_regfile.sv
// Register file: NREG entries, two combinational read ports, one write port
// and one fixed debug read port. Assumes entry 0 is constant zero; reset
// clears all entries synchronously.
module rvl_regfile #(
    parameter int XLEN    = 32,
    parameter int NREG    = 8,
    parameter int DBG_IDX = 3,
    localparam int RAW    = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    output logic [XLEN-1:0] dbg_q
);

    logic [XLEN-1:0] regs [NREG];

    // Entry 0 is a constant; entries 1..NREG-1 are flops
    assign regs[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        // Clear on reset, otherwise capture on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && wa == RAW'(g))
                regs[g] <= wd;
        end
    end

    assign rd1   = regs[ra1];
    assign rd2   = regs[ra2];
    assign dbg_q = regs[DBG_IDX];

endmodule

// File: rtl/rvl_alu.sv
// ALU: add, subtract, and, or, signed set-less-than. Also flags equality of
// the two operands for the branch compare.
module rvl_alu
    import rvl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            eq
);

    // Operation select
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
            default: y = a + b;
        endcase
    end

    assign eq = (a == b);

endmodule

// File: rtl/rvl_wordmem.sv
// Word memory: DEPTH words, combinational read, write on the rising edge.
// Assumes the caller supplies word indices (byte bits already dropped).
module rvl_wordmem #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Synchronous write port
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rvl_core.sv
// Single-cycle core top: PC, instruction memory, decoder, register file,
// immediate generator, ALU, data memory and writeback select. Each
// instruction completes in one clock. Assumes the instruction memory is
// filled through the load port while rst_n is low.
module rvl_core
    import rvl_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int NREG        = 8,
    parameter int IMEM_WORDS  = 64,
    parameter int DMEM_WORDS  = 64,
    parameter int DBG_IDX     = 3,
    localparam int IMEM_AW    = $clog2(IMEM_WORDS),
    localparam int DMEM_AW    = $clog2(DMEM_WORDS),
    localparam int RAW        = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_we,
    input  logic [IMEM_AW-1:0] load_addr,
    input  logic [31:0]        load_data,
    output logic [XLEN-1:0]    pc_o,
    output logic [XLEN-1:0]    dbg_o
);

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, pc_target;
    logic [31:0]     instr;
    ctrl_t           ctl;
    logic [XLEN-1:0] imm, rs1_data, rs2_data, alu_b, alu_y, mem_rdata, wb_data;
    logic            alu_eq, br_taken;

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else
            pc_q <= pc_next;
    end

    rvl_wordmem #(.W(32), .DEPTH(IMEM_WORDS)) u_imem (
        .clk   (clk),
        .we    (load_we),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (pc_q[IMEM_AW+1:2]),
        .rdata (instr)
    );

    rvl_decoder u_dec (
        .opcode (instr[6:0]),
        .funct3 (instr[14:12]),
        .funct7 (instr[31:25]),
        .ctrl   (ctl)
    );

    rvl_immgen #(.XLEN(XLEN)) u_imm (
        .ib   (instr[31:7]),
        .kind (ctl.imm_kind),
        .imm  (imm)
    );

    rvl_regfile #(.XLEN(XLEN), .NREG(NREG), .DBG_IDX(DBG_IDX)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.reg_we),
        .wa    (instr[7+RAW-1:7]),
        .wd    (wb_data),
        .ra1   (instr[15+RAW-1:15]),
        .ra2   (instr[20+RAW-1:20]),
        .rd1   (rs1_data),
        .rd2   (rs2_data),
        .dbg_q (dbg_o)
    );

    assign alu_b = ctl.b_is_imm ? imm : rs2_data;

    rvl_alu #(.XLEN(XLEN)) u_alu (
        .a  (rs1_data),
        .b  (alu_b),
        .op (ctl.alu_op),
        .y  (alu_y),
        .eq (alu_eq)
    );

    rvl_wordmem #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
        .clk   (clk),
        .we    (ctl.mem_we & rst_n),
        .waddr (alu_y[DMEM_AW+1:2]),
        .wdata (rs2_data),
        .raddr (alu_y[DMEM_AW+1:2]),
        .rdata (mem_rdata)
    );

    assign pc_plus4  = pc_q + XLEN'(4);
    assign pc_target = pc_q + imm;
    assign br_taken  = ctl.branch & (alu_eq ^ ctl.br_ne);

    // Writeback source select
    always_comb begin
        unique case (ctl.wb_sel)
            WB_MEM:  wb_data = mem_rdata;
            WB_PC4:  wb_data = pc_plus4;
            default: wb_data = alu_y;
        endcase
    end

    // Next-PC select: default sequential, redirect on taken branch or jump
    always_comb begin
        if (ctl.jalr)
            pc_next = {alu_y[XLEN-1:1], 1'b0};
        else if (ctl.jump || br_taken)
            pc_next = pc_target;
        else
            pc_next = pc_plus4;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/rvl_core_chk.sv
// Checker for rvl_core: temporal properties on the PC sequence, register 0
// and the store/writeback exclusion. Attached with bind below.
module rvl_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_q,
    input logic [XLEN-1:0] imm,
    input logic [XLEN-1:0] rs1_data,
    input logic [2:0]      rs1_idx,
    input logic            branch,
    input logic            jump,
    input logic            jalr,
    input logic            br_taken,
    input logic            reg_we,
    input logic            mem_we
);

    p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump && !br_taken) |=> pc_q == $past(pc_q) + XLEN'(4));

    p_branch_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (branch && br_taken) |=> pc_q == $past(pc_q + imm));

    p_jalr_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        jalr |=> pc_q == ($past(rs1_data + imm) & ~XLEN'(1)));

    p_pc_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[0] == 1'b0);

    p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_idx == 3'd0) |-> rs1_data == '0);

    p_store_no_rf_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !reg_we);

endmodule

bind rvl_core rvl_core_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_q     (pc_q),
    .imm      (imm),
    .rs1_data (rs1_data),
    .rs1_idx  (instr[17:15]),
    .branch   (ctl.branch),
    .jump     (ctl.jump),
    .jalr     (ctl.jalr),
    .br_taken (br_taken),
    .reg_we   (ctl.reg_we),
    .mem_we   (ctl.mem_we)
);

// File: tb/rvl_core_bench.sv
`timescale 1ns/1ps
module rvl_core_bench;

    localparam int NW  = 64;
    localparam int AW  = $clog2(NW);

    // Instruction encoders (RV32 formats)
    function automatic logic [31:0] enc_r(input int f7, input int rs2, input int rs1,
                                          input int f3, input int rd);
        enc_r = {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], 7'b0110011};
    endfunction
    function automatic logic [31:0] enc_i(input int imm, input int rs1, input int f3,
                                          input int rd, input int op);
        enc_i = {imm[11:0], rs1[4:0], f3[2:0], rd[4:0], op[6:0]};
    endfunction
    function automatic logic [31:0] enc_s(input int imm, input int rs2, input int rs1);
        enc_s = {imm[11:5], rs2[4:0], rs1[4:0], 3'b010, imm[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(input int imm, input int rs2, input int rs1,
                                          input int f3);
        enc_b = {imm[12], imm[10:5], rs2[4:0], rs1[4:0], f3[2:0], imm[4:1], imm[11],
                 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_j(input int imm, input int rd);
        enc_j = {imm[20], imm[10:1], imm[11], imm[19:12], rd[4:0], 7'b1101111};
    endfunction

    // Table rows: {instruction at address 8, expected x3}; x1=-7, x2=12 beforehand
    localparam logic [63:0] VEC [12] = '{
        {enc_r(0, 2, 1, 0, 3),                32'h0000_0005},  // R2 add
        {enc_r(32, 2, 1, 0, 3),               32'hFFFF_FFED},  // R2 sub
        {enc_r(0, 2, 1, 7, 3),                32'h0000_0008},  // R2 and
        {enc_r(0, 2, 1, 6, 3),                32'hFFFF_FFFD},  // R2 or
        {enc_r(0, 2, 1, 2, 3),                32'h0000_0001},  // R2 slt true
        {enc_r(0, 1, 2, 2, 3),                32'h0000_0000},  // R2 slt false
        {enc_i(-1, 1, 0, 3, 7'h13),           32'hFFFF_FFF8},  // R3 negative imm
        {enc_i(2047, 2, 0, 3, 7'h13),         32'h0000_080B},  // R3 max imm
        {enc_r(0, 2, 1, 0, 11),               32'h0000_0005},  // R4 rd=11 -> 3
        {enc_r(0, 2, 9, 0, 3),                32'h0000_0005},  // R4 rs1=9 -> 1
        {enc_r(0, 2, 0, 0, 3),                32'h0000_000C},  // R4 x0 reads zero
        {enc_r(1, 2, 1, 0, 3),                32'h0000_0000}   // R9 bad funct7
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_we = 1'b0;
    logic [AW-1:0]   load_addr = '0;
    logic [31:0]     load_data = '0;
    logic [31:0]     pc_o, dbg_o;
    logic [31:0]     prog [NW];
    int              total = 0;
    int              bad = 0;

    always #2.5 clk = ~clk;

    rvl_core u_rvl_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .pc_o      (pc_o),
        .dbg_o     (dbg_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < NW; i++) prog[i] = 32'h0;
    endtask

    // Hold reset, write the whole image, then release reset
    task automatic boot();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < NW; i++) begin
            @(negedge clk);
            load_we   = 1'b1;
            load_addr = AW'(i);
            load_data = prog[i];
        end
        @(negedge clk);
        load_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Table walk: R2, R3, R4, R9 plus sequential PC of R1
        for (int v = 0; v < 12; v++) begin
            clear_prog();
            prog[0] = enc_i(-7, 0, 0, 1, 7'h13);
            prog[1] = enc_i(12, 0, 0, 2, 7'h13);
            prog[2] = VEC[v][63:32];
            boot();
            run(3);
            chk($sformatf("R2/R3/R4/R9 vec%0d", v), dbg_o, VEC[v][31:0]);
            chk($sformatf("R1 pc after vec%0d", v), pc_o, 32'd12);
        end

        // R9: unrecognised opcode only moves the PC
        clear_prog();
        prog[0] = {25'h1F_FFFF, 7'b1111111};
        boot();
        run(1);
        chk("R9 pc", pc_o, 32'd4);
        chk("R9 x3", dbg_o, 32'd0);

        // R4: write to x0 discarded
        clear_prog();
        prog[0] = enc_i(9, 0, 0, 0, 7'h13);
        prog[1] = enc_i(1, 0, 0, 3, 7'h13);
        boot();
        run(2);
        chk("R4 x0 write ignored", dbg_o, 32'd1);

        // R5, R12: store at 11 (rd field low bits = 3), load back from 8
        clear_prog();
        prog[0] = enc_i(100, 0, 0, 1, 7'h13);
        prog[1] = enc_s(11, 1, 0);
        prog[2] = enc_i(8, 0, 2, 3, 7'h03);
        boot();
        run(2);
        chk("R12 store leaves x3", dbg_o, 32'd0);
        run(1);
        chk("R5 load after store", dbg_o, 32'd100);

        // R6: BEQ taken skips two instructions
        clear_prog();
        prog[0] = enc_i(5, 0, 0, 1, 7'h13);
        prog[1] = enc_i(5, 0, 0, 2, 7'h13);
        prog[2] = enc_b(12, 2, 1, 0);
        prog[3] = enc_i(1, 0, 0, 3, 7'h13);
        prog[4] = enc_i(2, 0, 0, 3, 7'h13);
        prog[5] = enc_i(7, 3, 0, 3, 7'h13);
        boot();
        run(3);
        chk("R6 beq taken pc", pc_o, 32'd20);
        run(1);
        chk("R6 beq taken x3", dbg_o, 32'd7);

        // R6: BNE not taken falls through
        prog[2] = enc_b(12, 2, 1, 1);
        boot();
        run(3);
        chk("R6 bne not taken pc", pc_o, 32'd12);
        run(3);
        chk("R6 bne fallthrough x3", dbg_o, 32'd9);

        // R7: JAL link and target
        clear_prog();
        prog[0] = enc_j(12, 3);
        boot();
        run(1);
        chk("R7 jal pc", pc_o, 32'd12);
        chk("R7 jal link", dbg_o, 32'd4);

        // R8: JALR to odd target clears bit 0
        clear_prog();
        prog[0] = enc_i(21, 0, 0, 1, 7'h13);
        prog[1] = enc_i(4, 1, 0, 3, 7'h67);
        boot();
        run(2);
        chk("R8 jalr pc", pc_o, 32'd24);
        chk("R8 jalr link", dbg_o, 32'd8);

        // R11: sum 1..10 with backward BNE, then self-jump
        clear_prog();
        prog[0] = enc_i(1, 0, 0, 1, 7'h13);
        prog[1] = enc_i(11, 0, 0, 2, 7'h13);
        prog[2] = enc_r(0, 1, 3, 0, 3);
        prog[3] = enc_i(1, 1, 0, 1, 7'h13);
        prog[4] = enc_b(-8, 2, 1, 1);
        prog[5] = enc_j(0, 0);
        boot();
        run(40);
        chk("R11 sum", dbg_o, 32'd55);
        chk("R11 halt pc", pc_o, 32'd20);

        // R10: reset clears PC and registers
        @(negedge clk);
        rst_n = 1'b0;
        run(1);
        chk("R10 reset pc", pc_o, 32'd0);
        chk("R10 reset reg", dbg_o, 32'd0);
        run(3);
        chk("R10 pc held in reset", pc_o, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule